// File: doc/BRIEF.md
# Shared-Bus Request/Grant/Busy Arbiter

This block arbitrates one shared bus among several masters using three active-low signals: a request line and a grant line per master, and a single busy line shared by all of them. A central arbiter selects one pending requester and asserts its grant. Receiving a grant does not by itself give the master the bus. The granted master still has to wait until the busy line is released. It then claims busy and drops its request in the same cycle. When its transfer is done, it releases busy.

Each master has a small handshake FSM inside the block. A one-cycle `startReq` pulse launches a request. A transfer is modelled as a programmable number of cycles during which busy is held low. Granting and taking ownership are separate events, so the arbiter can hand out the next grant while the current owner still holds the bus. The next master then takes over on the first cycle after busy is released.

Top module: `busArbiterSystem`

## Requirements
- R1: A master's request line (reqN, active low) goes low in the cycle after a `startReq` pulse that arrives while that master is idle. A pulse that arrives while the master is already requesting or owning the bus has no effect.
- R2: While the arbiter has no pending grant and at least one request is low, it drives the chosen master's grant line (gntN, active low) low in the next cycle. At most one grant line is low at any time, and a grant only goes to a master whose request was low.
- R3: Among simultaneous requesters, the grant goes to the first requesting index after the last master that took ownership, wrapping modulo N. After reset the last owner is N-1, so index 0 is favoured first.
- R4: While a grant is pending (the granted master has neither taken over nor withdrawn), the grant vector stays unchanged and no other grant is issued.
- R5: A granted master that sees busyN high drives busyN low and releases its request in the next cycle. A master never claims busy while busyN is low. At most one master drives busy at any time.
- R6: A master holds busyN low for exactly holdLen cycles, where a holdLen of 0 is treated as 1, and then releases it.
- R7: When the granted master's request goes high in the same cycle that busyN first falls, the arbiter raises the grant in the next cycle and records that master as the last owner.
- R8: An `abortReq` pulse to a requesting master raises its request in the next cycle. If that master held a grant without claiming busy, the grant is withdrawn in the following cycle and the last owner is left unchanged.
- R9: During reset, all request lines, all grant lines and busyN are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startReq | input | N_MASTERS | One-cycle pulse per master to request the bus |
| abortReq | input | N_MASTERS | One-cycle pulse per master to give up a pending request |
| holdLen | input | N_MASTERS*LEN_W | Transfer length in cycles per master, master i in bits [i*LEN_W +: LEN_W] |
| reqN | output | N_MASTERS | Per-master bus request, active low |
| gntN | output | N_MASTERS | Per-master bus grant, active low |
| busyN | output | 1 | Shared bus busy, active low |

## Verification
A start pulse lowers the request one cycle later. A grant follows one cycle after that if the arbiter is idle. A takeover follows one cycle after the master sees both its grant and busy released, and the grant rises one cycle after the takeover. With an idle bus, the first busy-low cycle therefore comes three clock edges after the start pulse. Stimulus is applied on the falling edge. A behavioural reference model advances on each rising edge, and every output is compared on the next falling edge, so each expected value is sampled in the exact cycle it is due. Directed sequences check these latencies cycle by cycle, as well as grant holding during a long ownership, an abort with a pending grant, and the round-robin order. A long random phase then mixes starts, aborts and lengths.

// File: rtl/busArbPkg.sv
package busArbPkg;
  typedef struct packed {
    logic issue;
    logic takeover;
    logic withdraw;
  } arbStrobe_t;

  typedef enum logic {ARB_IDLE, ARB_HELD} arbState_t;

  typedef enum logic [1:0] {RQ_IDLE, RQ_WAIT, RQ_OWN} rqState_t;
endpackage

// File: rtl/busArbRequester.sv
module busArbRequester
  import busArbPkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             abortReq,
  input  logic [LEN_W-1:0] holdLen,
  input  logic             gntN,
  input  logic             busyN,
  output logic             reqN,
  output logic             claimN
);
  rqState_t         state;
  logic [LEN_W-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= RQ_IDLE;
      holdCnt <= '0;
    end else begin
      unique case (state)
        RQ_IDLE: if (startReq) state <= RQ_WAIT;
        RQ_WAIT: begin
          if (abortReq) begin
            state <= RQ_IDLE;
          end else if (!gntN && busyN) begin
            state   <= RQ_OWN;
            holdCnt <= (holdLen == '0) ? LEN_W'(1) : holdLen;
          end
        end
        RQ_OWN: begin
          if (holdCnt <= LEN_W'(1)) state <= RQ_IDLE;
          else holdCnt <= holdCnt - LEN_W'(1);
        end
        default: state <= RQ_IDLE;
      endcase
    end
  end

  assign reqN   = (state != RQ_WAIT);
  assign claimN = (state != RQ_OWN);

  // R5: a claim only follows a cycle with own grant low and busy released
  p_claim_on_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!claimN && $past(claimN)) |-> ($past(!gntN) && $past(busyN)));

  // R5: request is released together with the claim
  p_req_drop_on_claim_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!claimN && $past(claimN)) |-> (reqN && $past(!reqN)));

  // R6: ownership continues while more than one hold cycle remains
  p_hold_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!claimN && holdCnt > LEN_W'(1)) |=> !claimN);
endmodule

// File: rtl/busArbCtrl.sv
module busArbCtrl
  import busArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       grantDrop,
  input  logic       busyFell,
  output arbStrobe_t strobe
);
  arbState_t state;

  always_comb begin
    strobe = '0;
    if (state == ARB_IDLE) begin
      strobe.issue = anyReq;
    end else if (grantDrop) begin
      strobe.takeover = busyFell;
      strobe.withdraw = !busyFell;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ARB_IDLE;
    else if (strobe.issue) state <= ARB_HELD;
    else if (strobe.takeover || strobe.withdraw) state <= ARB_IDLE;
  end

  // R4: at most one action per cycle
  p_one_action_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.issue, strobe.takeover, strobe.withdraw}));
endmodule

// File: rtl/busArbDatapath.sv
module busArbDatapath
  import busArbPkg::*;
#(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  arbStrobe_t           strobe,
  input  logic [N_MASTERS-1:0] reqN,
  input  logic                 busyN,
  output logic [N_MASTERS-1:0] gntN,
  output logic                 anyReq,
  output logic                 grantDrop,
  output logic                 busyFell
);
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

  logic [N_MASTERS-1:0] gntVec;
  logic [IDX_W-1:0]     gntIdx;
  logic [IDX_W-1:0]     lastOwner;
  logic [IDX_W-1:0]     pick;
  logic                 prevBusyN;

  always_comb begin
    int cand;
    pick = lastOwner;
    for (int k = N_MASTERS; k >= 1; k--) begin
      cand = (int'(lastOwner) + k) % N_MASTERS;
      if (!reqN[cand]) pick = IDX_W'(cand);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gntVec    <= '0;
      gntIdx    <= '0;
      lastOwner <= IDX_W'(N_MASTERS - 1);
      prevBusyN <= 1'b1;
    end else begin
      prevBusyN <= busyN;
      if (strobe.issue) begin
        gntVec <= N_MASTERS'(1) << pick;
        gntIdx <= pick;
      end else if (strobe.takeover) begin
        gntVec    <= '0;
        lastOwner <= gntIdx;
      end else if (strobe.withdraw) begin
        gntVec <= '0;
      end
    end
  end

  assign gntN      = ~gntVec;
  assign anyReq    = ~&reqN;
  assign grantDrop = |(gntVec & reqN);
  assign busyFell  = !busyN && prevBusyN;

  // R2: never more than one grant
  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gntVec));

  // R2: a fresh grant lands only on a master that was requesting
  p_grant_to_requester_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((gntVec & ~$past(gntVec)) != '0) |-> ((gntVec & $past(reqN)) == '0));

  // R4: pending grant is held steady
  p_hold_grant_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((gntVec != '0) && !grantDrop) |=> $stable(gntVec));

  // R7: takeover releases the grant next cycle
  p_release_after_takeover_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((gntVec != '0) && grantDrop && busyFell) |=> (gntVec == '0));
endmodule

// File: rtl/busArbiterSystem.sv
module busArbiterSystem
  import busArbPkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int LEN_W     = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [N_MASTERS-1:0]       startReq,
  input  logic [N_MASTERS-1:0]       abortReq,
  input  logic [N_MASTERS*LEN_W-1:0] holdLen,
  output logic [N_MASTERS-1:0]       reqN,
  output logic [N_MASTERS-1:0]       gntN,
  output logic                       busyN
);
  arbStrobe_t           strobe;
  logic                 anyReq;
  logic                 grantDrop;
  logic                 busyFell;
  logic [N_MASTERS-1:0] claimVecN;

  busArbCtrl uCtrl (
    .clk(clk), .rstN(rstN), .anyReq(anyReq), .grantDrop(grantDrop),
    .busyFell(busyFell), .strobe(strobe)
  );

  busArbDatapath #(.N_MASTERS(N_MASTERS)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqN(reqN), .busyN(busyN),
    .gntN(gntN), .anyReq(anyReq), .grantDrop(grantDrop), .busyFell(busyFell)
  );

  for (genvar i = 0; i < N_MASTERS; i++) begin : gMaster
    busArbRequester #(.LEN_W(LEN_W)) uReq (
      .clk(clk), .rstN(rstN), .startReq(startReq[i]), .abortReq(abortReq[i]),
      .holdLen(holdLen[i*LEN_W +: LEN_W]), .gntN(gntN[i]), .busyN(busyN),
      .reqN(reqN[i]), .claimN(claimVecN[i])
    );
  end

  assign busyN = &claimVecN;

  // R5: only one master drives busy
  p_single_owner_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~claimVecN) <= 1);

  // R9: idle lines while in reset
  p_reset_idle_r9: assert property (@(posedge clk)
    $past(!rstN) |-> (&reqN && &gntN && busyN));
endmodule

// File: tb/busArbiterSystem_test.sv
`timescale 1ns/1ps
module busArbiterSystem_test;
  localparam int N = 4;
  localparam int LW = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [N-1:0]    startReq = '0;
  logic [N-1:0]    abortReq = '0;
  logic [N*LW-1:0] holdLen = '0;
  logic [N-1:0]    reqN, gntN;
  logic            busyN;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  busArbiterSystem #(.N_MASTERS(N), .LEN_W(LW)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .holdLen(holdLen), .reqN(reqN), .gntN(gntN), .busyN(busyN)
  );

  // reference model: 0 idle, 1 requesting, 2 owning
  int ms[N];
  int mc[N];
  bit mHeld;
  int mG;
  int mLast;
  bit mPrevBusy;

  function automatic logic [N-1:0] expReqN();
    for (int i = 0; i < N; i++) expReqN[i] = (ms[i] != 1);
  endfunction

  function automatic logic expBusyN();
    expBusyN = 1'b1;
    for (int i = 0; i < N; i++) if (ms[i] == 2) expBusyN = 1'b0;
  endfunction

  function automatic logic [N-1:0] expGntN();
    expGntN = '1;
    if (mHeld) expGntN[mG] = 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin ms[i] = 0; mc[i] = 0; end
      mHeld = 0; mG = 0; mLast = N - 1; mPrevBusy = 0;
    end else begin
      int nms[N];
      int nmc[N];
      bit busyNow;
      busyNow = !expBusyN();
      for (int i = 0; i < N; i++) begin
        nms[i] = ms[i]; nmc[i] = mc[i];
        if (ms[i] == 0) begin
          if (startReq[i]) nms[i] = 1;
        end else if (ms[i] == 1) begin
          if (abortReq[i]) nms[i] = 0;
          else if (mHeld && mG == i && !busyNow) begin
            int l;
            l = int'(holdLen[i*LW +: LW]);
            nms[i] = 2; nmc[i] = (l == 0) ? 1 : l;
          end
        end else begin
          if (mc[i] <= 1) nms[i] = 0;
          else nmc[i] = mc[i] - 1;
        end
      end
      if (mHeld) begin
        if (ms[mG] != 1) begin
          if (busyNow && !mPrevBusy) mLast = mG;
          mHeld = 0;
        end
      end else begin
        for (int k = 1; k <= N; k++) begin
          int c;
          c = (mLast + k) % N;
          if (!mHeld && ms[c] == 1) begin mHeld = 1; mG = c; end
        end
      end
      mPrevBusy = busyNow;
      for (int i = 0; i < N; i++) begin ms[i] = nms[i]; mc[i] = nmc[i]; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(reqN == expReqN(), "R1 reqN vs model", reqN, expReqN());
      chk(gntN == expGntN(), "R2 gntN vs model", gntN, expGntN());
      chk(busyN == expBusyN(), "R6 busyN vs model", busyN, expBusyN());
    end
  end

  // record order of newly issued grants
  int order[$];
  logic [N-1:0] prevGnt = '1;
  always @(negedge clk) begin
    if (rstN && gntN != prevGnt && gntN != '1)
      for (int i = 0; i < N; i++) if (!gntN[i]) order.push_back(i);
    prevGnt = gntN;
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      startReq = '0;
      abortReq = '0;
    end
  endtask

  task automatic setLen(input int i, input int l);
    holdLen[i*LW +: LW] = LW'(l);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk(reqN == '1, "R9 reset reqN", reqN, '1);
    chk(gntN == '1, "R9 reset gntN", gntN, '1);
    chk(busyN == 1'b1, "R9 reset busyN", busyN, 1);
    rstN = 1'b1;
    step(2);

    // basic latency: master 0, length 3
    setLen(0, 3);
    startReq[0] = 1'b1;
    step();
    chk(reqN[0] == 1'b0, "R1 request one cycle after start", reqN[0], 0);
    step();
    chk(gntN == 4'b1110, "R2 grant one cycle after request", gntN, 4'b1110);
    step();
    chk(busyN == 1'b0 && reqN[0] == 1'b1, "R5 claim and drop request",
        {busyN, reqN[0]}, 2'b01);
    step();
    chk(gntN == '1, "R7 grant raised after takeover", gntN, '1);
    startReq[0] = 1'b1; // ignored while owning
    step();
    chk(busyN == 1'b0, "R6 busy third cycle", busyN, 0);
    chk(reqN[0] == 1'b1, "R1 start ignored while owning", reqN[0], 1);
    step();
    chk(busyN == 1'b1, "R6 busy released after holdLen", busyN, 1);
    step(4);

    // grant pending while another master owns
    setLen(0, 6); setLen(1, 2);
    startReq[0] = 1'b1;
    step(3);
    startReq[1] = 1'b1;
    step(2);
    chk(gntN == 4'b1101 && busyN == 1'b0, "R4 grant given while bus owned",
        {gntN, busyN}, {4'b1101, 1'b0});
    step(2);
    chk(gntN == 4'b1101 && reqN[1] == 1'b0, "R4 grant held pending",
        {gntN, reqN[1]}, {4'b1101, 1'b0});
    step(12);

    // abort with pending grant
    setLen(0, 8);
    startReq[0] = 1'b1;
    step(3);
    startReq[3] = 1'b1;
    step(2);
    chk(gntN == 4'b0111, "R8 grant to master 3 pending", gntN, 4'b0111);
    abortReq[3] = 1'b1;
    step();
    chk(reqN[3] == 1'b1, "R8 request dropped after abort", reqN[3], 1);
    step();
    chk(gntN == '1, "R8 grant withdrawn", gntN, '1);
    step(12);

    // round robin: last owner is 0, so order is 1,2,3,0
    order.delete();
    for (int i = 0; i < N; i++) setLen(i, 1);
    startReq = '1;
    step(30);
    chk(order.size() == 4, "R3 grant count", order.size(), 4);
    if (order.size() == 4) begin
      chk(order[0] == 1 && order[1] == 2 && order[2] == 3 && order[3] == 0,
          "R3 round-robin order", order[0]*1000 + order[1]*100 + order[2]*10 + order[3],
          1230);
    end

    // random phase
    for (int c = 0; c < 4000; c++) begin
      startReq = N'($urandom) & N'($urandom);
      abortReq = N'($urandom) & N'($urandom) & N'($urandom);
      for (int i = 0; i < N; i++) setLen(i, int'($urandom % 6));
      @(posedge clk);
      @(negedge clk);
    end
    startReq = '0; abortReq = '0;
    step(60);
    chk(busyN == 1'b1 && gntN == '1, "R7 bus quiet at end", {busyN, gntN}, 5'h1f);
    summary();
  end
endmodule